// File: doc/BRIEF.md
# Status-Tagged UART Receive Queue

This block is the receive half of a fixed 8N1 serial port. A receiver front end hands it one deserialized byte at a time, together with a framing-error mark and a break mark. The block keeps each byte and its two marks in a 64-entry first-in first-out queue. A read of the data register returns the oldest entry as one 32-bit word. That word carries the byte, both marks and an empty indication, so software never has to read status before it pops.

The block also reports how full the queue is and runs an inactivity timer measured in character times of the baud tick. It keeps a set of latched event flags that software clears by writing ones, and it combines those flags into one interrupt line through two enables. A receive threshold, chosen from six levels, raises a live flag once enough bytes are waiting.

Access is through a plain register port. A 2-bit address selects one of four registers: 0 is data, 1 is level, 2 is status and 3 is control. Reads are combinational. Writes, and the pop caused by a data read, take effect at the clock edge that closes the access.

Top module: `uart_rxq`

## Requirements
- R1: A data-register read returns the received byte in bits 7:0, the framing mark in bit 9 and the break mark in bit 10. On an empty queue the read returns exactly 0x100 (bit 8 set, all other bits zero) and the queue is left unchanged.
- R2: Bytes leave the queue in arrival order, and the queue holds up to 64 entries.
- R3: A byte that arrives while the queue is full is discarded and the stored entries are kept. A read in the same cycle does not free room for it. Status bit 5 (overrun) is set.
- R4: The level register reports the receive queue occupancy in bits 7:0 and the transmit occupancy input in bits 15:8. All other bits read zero.
- R5: Status bit 1 is live, not latched. It reads 1 while the occupancy is at or above the threshold chosen by control bits 4:2: codes 0 to 5 give 1, 4, 8, 16, 32 and 48, and codes 6 and 7 give 48.
- R6: Control bits 17:16 set the inactivity timeout. Code 0 turns it off, and codes 1, 2 and 3 give 4, 8 and 16 character times of 10 baud ticks each. When that many ticks pass with data waiting and no restart, status bit 2 is set.
- R7: The inactivity count restarts on every stored byte and on every data read that pops an entry.
- R8: Status bits 2, 3 (framing), 4 (break) and 5 (overrun) latch when their event occurs. Bits 3 and 4 are set only by stored bytes. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear fall in the same cycle, the event wins.
- R9: The interrupt output is high when control bit 6 is set and status bit 1 or 2 is high, or when control bit 7 is set and status bit 3, 4 or 5 is high.
- R10: After reset the queue is empty, the control register and status read zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe from the front end: a byte is ready |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Byte had a bad stop bit |
| rx_break | input | 1 | Byte is a break condition |
| baud_tick | input | 1 | One pulse per bit period |
| tx_level | input | 8 | Transmit queue occupancy, passed into the level register |
| reg_addr | input | 2 | Register select: 0 data, 1 level, 2 status, 3 control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a data read pops the queue |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong pointer or occupancy count shows up at the ports on the very next access. Either the data word carries the wrong byte or marks, or the level register drifts from the number of pushes minus pops, and the order test catches this within one read. A miscounted timer moves the moment status bit 2 rises by whole ticks. For that reason the bench samples the cycle just before the expected expiry and the cycle of the expiry itself, for several codes and after both kinds of restart. A faulty flag latch or enable appears as a status or interrupt value that differs one cycle after the event or clearing write that should have changed it.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    A_DATA  = 2'd0,
    A_LEVEL = 2'd1,
    A_STAT  = 2'd2,
    A_CTRL  = 2'd3
  } rxq_addr_e;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic [7:0] data;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);

  // status bit positions
  localparam int ST_TRIG = 1;
  localparam int ST_TMO  = 2;
  localparam int ST_FE   = 3;
  localparam int ST_BRK  = 4;
  localparam int ST_OVR  = 5;

  // control field positions
  localparam int CT_TRIG_LO = 2;
  localparam int CT_RX_IE   = 6;
  localparam int CT_ERR_IE  = 7;
  localparam int CT_TMO_LO  = 16;
  localparam logic [31:0] CTRL_MASK = 32'h0003_00DC;

  // receive threshold in bytes for a trigger code
  function automatic int unsigned trig_threshold(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  // inactivity window in character times (0 = off)
  function automatic int unsigned tmo_chars(input logic [1:0] code);
    case (code)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import uart_rxq_pkg::*;
#(
  parameter int BITS_PER_CHAR = 10,
  localparam int MAX_TICKS    = 16 * BITS_PER_CHAR,
  localparam int CNT_W        = $clog2(MAX_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  logic       tick,
  input  logic       armed,
  input  logic       restart,
  output logic       expire
);

  logic [CNT_W-1:0] cnt, limit;
  logic             enabled;

  assign limit   = CNT_W'(tmo_chars(code) * BITS_PER_CHAR);
  assign enabled = (code != 2'd0);
  assign expire  = enabled && armed && tick && !restart && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !armed || !enabled) begin
      cnt <= '0;
    end else if (tick && cnt < limit) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int BITS_PER_CHAR = 10,
  localparam int CW           = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_frame_err,
  input  logic        rx_break,
  input  logic        baud_tick,
  input  logic [7:0]  tx_level,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);

  rxq_entry_t       in_entry, head;
  logic [CW-1:0]    fifo_count;
  logic             full, empty;
  logic             pop_req, push_acc, pop_acc, overrun_ev;
  logic             tmo_expire;
  logic [31:0]      ctrl_q;
  logic [2:0]       trig_code;
  logic [1:0]       tmo_code;
  logic             rx_ie, err_ie;
  logic [CW-1:0]    trig_thr;
  logic             trig_live;
  logic [3:0]       ev_set, ev_clr, ev_flag;
  logic             tmo_flag, fe_flag, brk_flag, ovr_flag;
  logic [31:0]      data_word, level_word, stat_word;

  // ---------------- control register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
  end

  assign trig_code = ctrl_q[CT_TRIG_LO +: 3];
  assign tmo_code  = ctrl_q[CT_TMO_LO +: 2];
  assign rx_ie     = ctrl_q[CT_RX_IE];
  assign err_ie    = ctrl_q[CT_ERR_IE];

  // ---------------- queue ----------------
  assign in_entry   = '{brk: rx_break, fe: rx_frame_err, data: rx_data};
  assign pop_req    = reg_rd && (reg_addr == A_DATA);
  assign push_acc   = rx_valid && !full;
  assign pop_acc    = pop_req && !empty;
  assign overrun_ev = rx_valid && full;

  rxq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_valid),
    .wdata (in_entry),
    .pop   (pop_req),
    .head  (head),
    .count (fifo_count),
    .full  (full),
    .empty (empty)
  );

  // ---------------- inactivity timer ----------------
  rxq_idle_timer #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (tmo_code),
    .tick    (baud_tick),
    .armed   (!empty),
    .restart (push_acc || pop_acc),
    .expire  (tmo_expire)
  );

  // ---------------- receive threshold ----------------
  always_comb begin
    if (trig_threshold(trig_code) > DEPTH) trig_thr = CW'(DEPTH);
    else                                   trig_thr = CW'(trig_threshold(trig_code));
  end
  assign trig_live = (fifo_count >= trig_thr);

  // ---------------- latched flags: [0]=tmo [1]=fe [2]=brk [3]=ovr ----------------
  assign ev_set = {overrun_ev,
                   push_acc && rx_break,
                   push_acc && rx_frame_err,
                   tmo_expire};
  assign ev_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[ST_TMO +: 4] : 4'b0;

  rxq_flags #(.N(4)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr   (ev_clr),
    .flag  (ev_flag)
  );

  assign {ovr_flag, brk_flag, fe_flag, tmo_flag} = ev_flag;

  // ---------------- read mux ----------------
  always_comb begin
    data_word = 32'h0000_0100;
    if (!empty) data_word = {21'b0, head.brk, head.fe, 1'b0, head.data};
  end

  assign level_word = {16'b0, tx_level, 8'(fifo_count)};

  always_comb begin
    stat_word          = '0;
    stat_word[ST_TRIG] = trig_live;
    stat_word[ST_TMO]  = tmo_flag;
    stat_word[ST_FE]   = fe_flag;
    stat_word[ST_BRK]  = brk_flag;
    stat_word[ST_OVR]  = ovr_flag;
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = data_word;
      A_LEVEL: reg_rdata = level_word;
      A_STAT:  reg_rdata = stat_word;
      default: reg_rdata = ctrl_q;
    endcase
  end

  assign irq = (rx_ie && (trig_live || tmo_flag)) ||
               (err_ie && (fe_flag || brk_flag || ovr_flag));

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fifo_count,
  input logic          full,
  input logic          empty,
  input logic          rx_valid,
  input logic          pop_acc,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          ovr_flag,
  input logic          tmo_flag,
  input logic [1:0]    tmo_code,
  input logic          rx_ie,
  input logic          err_ie,
  input logic          irq
);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r3_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && !pop_acc) |=> (fifo_count == $past(fifo_count)));

  a_r3_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid) |=> ovr_flag);

  a_r1_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && empty) |-> (reg_rdata == 32'h0000_0100));

  a_r1_empty_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && empty && !rx_valid) |=> (fifo_count == '0));

  a_r8_w1c_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[5] && !(full && rx_valid)) |=> !ovr_flag);

  a_r6_timeout_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_code == 2'd0) |=> !$rose(tmo_flag));

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !err_ie) |-> !irq);

endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_count (fifo_count),
  .full       (full),
  .empty      (empty),
  .rx_valid   (rx_valid),
  .pop_acc    (pop_acc),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ovr_flag   (ovr_flag),
  .tmo_flag   (tmo_flag),
  .tmo_code   (tmo_code),
  .rx_ie      (rx_ie),
  .err_ie     (err_ie),
  .irq        (irq)
);

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_frame_err = 1'b0;
  logic        rx_break = 1'b0;
  logic        baud_tick = 1'b0;
  logic [7:0]  tx_level = 8'h2C;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_rxq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break), .baud_tick(baud_tick),
    .tx_level(tx_level), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {trigger code, expected threshold}
  localparam logic [15:0] TRIG_VEC [8] = '{
    {8'd0, 8'd1}, {8'd1, 8'd4}, {8'd2, 8'd8}, {8'd3, 8'd16},
    {8'd4, 8'd32}, {8'd5, 8'd48}, {8'd6, 8'd48}, {8'd7, 8'd48}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic push(input logic [7:0] d, input logic fe, input logic brk);
    rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_break = brk;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    #1 chk("R10 irq", {31'b0, irq}, 32'h0);
    rd(2'd3, v); chk("R10 control", v, 32'h0);
    rd(2'd2, v); chk("R10 status", v, 32'h0);
    rd(2'd1, v); chk("R4/R10 level", v, 32'h0000_2C00);
    rd(2'd0, v); chk("R1 empty read", v, 32'h0000_0100);
    rd(2'd1, v); chk("R1 empty read leaves level", v, 32'h0000_2C00);

    // R1 R2 R4 word format, order, marks
    push(8'h41, 1'b0, 1'b0);
    push(8'h5A, 1'b1, 1'b0);
    push(8'h00, 1'b0, 1'b1);
    rd(2'd1, v); chk("R4 level", v, 32'h0000_2C03);
    rd(2'd2, v); chk("R8 fe/brk latched", v & 32'h18, 32'h18);
    rd(2'd0, v); chk("R1/R2 first", v, 32'h0000_0041);
    rd(2'd0, v); chk("R1/R2 fe mark", v, 32'h0000_025A);
    rd(2'd0, v); chk("R1/R2 brk mark", v, 32'h0000_0400);
    rd(2'd0, v); chk("R1 empty after drain", v, 32'h0000_0100);

    // R8 write-one-to-clear
    wr(2'd2, 32'h08); rd(2'd2, v); chk("R8 clear fe only", v, 32'h10);
    wr(2'd2, 32'h00); rd(2'd2, v); chk("R8 write zero no effect", v, 32'h10);
    wr(2'd2, 32'h10); rd(2'd2, v); chk("R8 clear brk", v, 32'h00);

    // R9 interrupt gating
    wr(2'd3, 32'h80);
    push(8'h11, 1'b1, 1'b0);
    #1 chk("R9 err irq", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h08);
    #1 chk("R9 err irq cleared", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'h40);
    #1 chk("R9 rx irq from trigger", {31'b0, irq}, 32'h1);
    rd(2'd0, v);
    #1 chk("R9 rx irq drops", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'h00);

    // R5 trigger thresholds, table walk
    for (int i = 0; i < 8; i++) begin
      int thr;
      thr = int'(TRIG_VEC[i][7:0]);
      wr(2'd3, {27'b0, TRIG_VEC[i][10:8], 2'b00});
      for (int k = 0; k < thr - 1; k++) push(8'(k), 1'b0, 1'b0);
      rd(2'd2, v); chk("R5 below threshold", v & 32'h2, 32'h0);
      push(8'hA5, 1'b0, 1'b0);
      rd(2'd2, v); chk("R5 at threshold", v & 32'h2, 32'h2);
      for (int k = 0; k < thr; k++) rd(2'd0, v);
      rd(2'd1, v); chk("R5 drained", v & 32'hFF, 32'h0);
    end
    wr(2'd3, 32'h0);

    // R3 overrun, R2 depth and order
    for (int k = 0; k < 64; k++) push(8'(k + 3), 1'b0, 1'b0);
    rd(2'd1, v); chk("R2 full level", v & 32'hFF, 32'd64);
    rd(2'd2, v); chk("R3 no overrun yet", v & 32'h20, 32'h0);
    push(8'hEE, 1'b0, 1'b0);
    rd(2'd1, v); chk("R3 level kept", v & 32'hFF, 32'd64);
    rd(2'd2, v); chk("R3 overrun flag", v & 32'h20, 32'h20);
    for (int k = 0; k < 64; k++) begin
      rd(2'd0, v); chk("R2/R3 order kept", v, 32'(k + 3));
    end
    rd(2'd0, v); chk("R3 dropped byte absent", v, 32'h100);
    wr(2'd2, 32'h20);

    // R6 timeout code 1: 40 ticks
    wr(2'd3, 32'h0001_0000);
    push(8'h01, 1'b0, 1'b0);
    baud_tick = 1'b1;
    edges(39);
    rd(2'd2, v); chk("R6 code1 before expiry", v & 32'h4, 32'h0);
    rd(2'd2, v); chk("R6 code1 expiry", v & 32'h4, 32'h4);

    // R7 restart on stored byte
    wr(2'd2, 32'h04);
    edges(30);
    push(8'h02, 1'b0, 1'b0);
    edges(39);
    rd(2'd2, v); chk("R7 push restart before", v & 32'h4, 32'h0);
    rd(2'd2, v); chk("R7 push restart expiry", v & 32'h4, 32'h4);

    // R7 restart on read
    wr(2'd2, 32'h04);
    edges(30);
    rd(2'd0, v); chk("R7 pop data", v, 32'h01);
    edges(39);
    rd(2'd2, v); chk("R7 pop restart before", v & 32'h4, 32'h0);
    rd(2'd2, v); chk("R7 pop restart expiry", v & 32'h4, 32'h4);
    wr(2'd2, 32'h04);
    rd(2'd0, v);

    // R6 code 2: 80 ticks
    wr(2'd3, 32'h0002_0000);
    push(8'h03, 1'b0, 1'b0);
    edges(79);
    rd(2'd2, v); chk("R6 code2 before expiry", v & 32'h4, 32'h0);
    rd(2'd2, v); chk("R6 code2 expiry", v & 32'h4, 32'h4);
    wr(2'd2, 32'h04);
    rd(2'd0, v);

    // R6 code 0: never
    wr(2'd3, 32'h0);
    push(8'h04, 1'b0, 1'b0);
    edges(200);
    rd(2'd2, v); chk("R6 code0 disabled", v & 32'h4, 32'h0);
    rd(2'd0, v);
    baud_tick = 1'b0;

    finish_run();
  end

endmodule